// File: doc/BRIEF.md
# Write-Once Clock Mode Register

This block holds the 8-bit control byte that steers a chip's clock tree. It chooses the main oscillator type, the system clock division, and whether each of the two oscillators runs. The actual switching of clocks happens elsewhere, downstream of the decoded fields that this block produces.

A runaway program must not be able to reprogram the oscillator type or the operating-mode bits. For that reason, bits 5, 1 and 0 are guarded. They accept exactly one plain write after reset and then freeze. A bit-set or bit-clear (read-modify-write) access also freezes them, without changing them. The remaining bits stay writable at any time.

The block also derives an effective division. When the register asks for the double-speed setting while RC oscillation is selected, that request is demoted to the next slower setting.

Top module: `clkmode_reg`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) sets the register to 8'h00 and clears the lock flag.
- R2: An access is a rising edge with wr_en=1 and addr_hit=1. The first plain access (rmw_op=0) after reset loads all eight bits from wdata and sets the lock flag.
- R3: Once the lock flag is set, a plain access still loads bits 7, 6, 4, 3 and 2 from wdata. Bits 5, 1 and 0 keep their value, and the lock flag stays set until reset.
- R4: A read-modify-write access (rmw_op=1) loads bits 7, 6, 4, 3 and 2 from wdata. It leaves bits 5, 1 and 0 unchanged and sets the lock flag, even as the first access after reset.
- R5: A rising edge with wr_en=0, or with addr_hit=0, changes neither the register nor the lock flag.
- R6: The field outputs map as follows:
  - div_sel_o is bits 7:6.
  - ceramic_o is bit 5 (1 = ceramic, 0 = RC).
  - main_osc_stop_o is bit 4 (1 = stopped).
  - onchip_osc_stop_o is bit 3 (1 = stopped).
  - mode_o is bits 1:0.
- R7: eff_div_o equals div_sel_o, except that div_sel 2'b01 (double speed) with bit 5 = 0 gives 2'b10. The division codes are 00 = run from the on-chip oscillator, 01 = double speed, 10 = divide by 2, 11 = divide by 8.
- R8: onchip_clk_o is 1 exactly when eff_div_o is 2'b00. It is therefore 1 after reset.
- R9: A reset applied after locking restores the defaults and allows one more full write of bits 5, 1 and 0.
- R10: All outputs are registered. An access at an edge becomes visible just after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rmw_op | input | 1 | Marks the write as a bit-set/bit-clear read-modify-write |
| addr_hit | input | 1 | Bus address selects this register |
| wdata | input | 8 | Write data |
| reg_o | output | 8 | Current register contents |
| lock_o | output | 1 | Guarded bits are frozen |
| div_sel_o | output | 2 | Requested division code |
| eff_div_o | output | 2 | Division code after the RC double-speed fallback |
| ceramic_o | output | 1 | 1 = ceramic source, 0 = RC source |
| main_osc_stop_o | output | 1 | Main oscillator stop request |
| onchip_osc_stop_o | output | 1 | On-chip oscillator stop request |
| onchip_clk_o | output | 1 | System clock taken from the on-chip oscillator |
| mode_o | output | 2 | Guarded operating-mode bits |

## Verification
Each test drives a different write pattern, and each one separates a distinct fault:
- **Single plain write after reset.** An all-ones pattern shows that every bit loads.
- **Second plain write.** It carries an inverted pattern, so a guard that fails to hold any of bits 5, 1 and 0 shows up at once.
- **Read-modify-write as the first access.** It uses a pattern that differs from the reset value in every bit. This tells a lock that is armed by RMW apart from one that is only armed by a plain write.
- **Strobe and address deasserted.** Writes with only one of the two asserted must leave everything unchanged.
- **Fallback sweep.** All four division codes are written with both oscillator types, resetting between each combination. This separates the fallback from a plain copy of the division bits.
- **Reset after locking.** A final reset followed by a write shows that the lock reopens.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned DIV_LO   = 6;
  localparam int unsigned SRC_BIT  = 5;
  localparam int unsigned MOSC_BIT = 4;
  localparam int unsigned IOSC_BIT = 3;
  localparam int unsigned MODE_LO  = 0;
  localparam int unsigned DIV_W    = 2;
  localparam int unsigned MODE_W   = 2;

  typedef enum logic [DIV_W-1:0] {
    DIV_ONCHIP = 2'b00,
    DIV_DOUBLE = 2'b01,
    DIV_HALF   = 2'b10,
    DIV_EIGHTH = 2'b11
  } div_code_t;

  function automatic logic [DIV_W-1:0] resolve_div(input logic [DIV_W-1:0] req,
                                                   input logic ceramic);
    if (req == DIV_DOUBLE && !ceramic) return DIV_HALF;
    return req;
  endfunction
endpackage

// File: rtl/clkmode_lock.sv
module clkmode_lock (
  input  logic clk,
  input  logic rst,
  input  logic access,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (rst)         locked <= 1'b0;
    else if (access) locked <= 1'b1;
  end
endmodule

// File: rtl/clkmode_store.sv
module clkmode_store #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] PROT_MASK = 8'h23,
  parameter logic [W-1:0] RESET_VAL = 8'h00
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         access,
  input  logic         rmw,
  input  logic         locked,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  // Guarded bits open only for a plain access while unlocked.
  logic guard_open;
  assign guard_open = access && !rmw && !locked;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (PROT_MASK[i]) begin : g_guarded
      assign nxt[i] = guard_open ? wdata[i] : q[i];
    end else begin : g_free
      assign nxt[i] = access ? wdata[i] : q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= nxt;
  end
endmodule

// File: rtl/clkmode_decode.sv
module clkmode_decode
  import clkmode_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_in,
  input  logic              src_in,
  input  logic              mosc_in,
  input  logic              iosc_in,
  input  logic [MODE_W-1:0] mode_in,
  output logic [DIV_W-1:0]  div_sel,
  output logic [DIV_W-1:0]  eff_div,
  output logic              ceramic,
  output logic              mosc_stop,
  output logic              iosc_stop,
  output logic              onchip_clk,
  output logic [MODE_W-1:0] mode
);
  localparam logic [DIV_W-1:0]  RST_DIV  = RESET_VAL[DIV_LO +: DIV_W];
  localparam logic              RST_SRC  = RESET_VAL[SRC_BIT];
  localparam logic [DIV_W-1:0]  RST_EFF  = resolve_div(RST_DIV, RST_SRC);

  logic [DIV_W-1:0] eff_nxt;
  assign eff_nxt = resolve_div(div_in, src_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_sel    <= RST_DIV;
      eff_div    <= RST_EFF;
      ceramic    <= RST_SRC;
      mosc_stop  <= RESET_VAL[MOSC_BIT];
      iosc_stop  <= RESET_VAL[IOSC_BIT];
      onchip_clk <= (RST_EFF == DIV_ONCHIP);
      mode       <= RESET_VAL[MODE_LO +: MODE_W];
    end else begin
      div_sel    <= div_in;
      eff_div    <= eff_nxt;
      ceramic    <= src_in;
      mosc_stop  <= mosc_in;
      iosc_stop  <= iosc_in;
      onchip_clk <= (eff_nxt == DIV_ONCHIP);
      mode       <= mode_in;
    end
  end
endmodule

// File: rtl/clkmode_reg.sv
module clkmode_reg
  import clkmode_pkg::*;
#(
  parameter logic [REG_W-1:0] PROT_MASK = 8'h23,
  parameter logic [REG_W-1:0] RESET_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rmw_op,
  input  logic              addr_hit,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  reg_o,
  output logic              lock_o,
  output logic [DIV_W-1:0]  div_sel_o,
  output logic [DIV_W-1:0]  eff_div_o,
  output logic              ceramic_o,
  output logic              main_osc_stop_o,
  output logic              onchip_osc_stop_o,
  output logic              onchip_clk_o,
  output logic [MODE_W-1:0] mode_o
);
  logic             access;
  logic [REG_W-1:0] nxt;

  assign access = wr_en && addr_hit;

  clkmode_lock u_lock (
    .clk    (clk),
    .rst    (rst),
    .access (access),
    .locked (lock_o)
  );

  clkmode_store #(
    .W         (REG_W),
    .PROT_MASK (PROT_MASK),
    .RESET_VAL (RESET_VAL)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .access (access),
    .rmw    (rmw_op),
    .locked (lock_o),
    .wdata  (wdata),
    .nxt    (nxt),
    .q      (reg_o)
  );

  clkmode_decode #(
    .RESET_VAL (RESET_VAL)
  ) u_decode (
    .clk        (clk),
    .rst        (rst),
    .div_in     (nxt[DIV_LO +: DIV_W]),
    .src_in     (nxt[SRC_BIT]),
    .mosc_in    (nxt[MOSC_BIT]),
    .iosc_in    (nxt[IOSC_BIT]),
    .mode_in    (nxt[MODE_LO +: MODE_W]),
    .div_sel    (div_sel_o),
    .eff_div    (eff_div_o),
    .ceramic    (ceramic_o),
    .mosc_stop  (main_osc_stop_o),
    .iosc_stop  (onchip_osc_stop_o),
    .onchip_clk (onchip_clk_o),
    .mode       (mode_o)
  );
endmodule

// File: rtl/clkmode_reg_chk.sv
module clkmode_reg_chk #(
  parameter logic [7:0] PROT_MASK = 8'h23
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rmw_op,
  input logic       addr_hit,
  input logic [7:0] reg_o,
  input logic       lock_o,
  input logic [1:0] eff_div_o,
  input logic       ceramic_o,
  input logic [1:0] div_sel_o,
  input logic       onchip_clk_o
);
  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> lock_o);

  p_guard_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    lock_o |=> $stable(reg_o & PROT_MASK));

  p_access_locks_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_hit) |=> lock_o);

  p_rmw_keeps_guard_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_hit && rmw_op) |=> $stable(reg_o & PROT_MASK));

  p_idle_no_change_r5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr_hit) |=> ($stable(reg_o) && $stable(lock_o)));

  p_no_double_on_rc_r7: assert property (@(posedge clk) disable iff (rst)
    !(eff_div_o == 2'b01 && !ceramic_o));

  p_eff_follows_ceramic_r7: assert property (@(posedge clk) disable iff (rst)
    ceramic_o |-> (eff_div_o == div_sel_o));

  p_onchip_flag_r8: assert property (@(posedge clk) disable iff (rst)
    onchip_clk_o == (eff_div_o == 2'b00));
endmodule

bind clkmode_reg clkmode_reg_chk #(.PROT_MASK(PROT_MASK)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .rmw_op       (rmw_op),
  .addr_hit     (addr_hit),
  .reg_o        (reg_o),
  .lock_o       (lock_o),
  .eff_div_o    (eff_div_o),
  .ceramic_o    (ceramic_o),
  .div_sel_o    (div_sel_o),
  .onchip_clk_o (onchip_clk_o)
);

// File: tb/clkmode_reg_test.sv
`timescale 1ns/1ps
module clkmode_reg_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rmw_op = 1'b0;
  logic       addr_hit = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] reg_o;
  logic       lock_o;
  logic [1:0] div_sel_o, eff_div_o, mode_o;
  logic       ceramic_o, main_osc_stop_o, onchip_osc_stop_o, onchip_clk_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m_val;
  logic       m_lock;
  localparam logic [7:0] GUARD = 8'h23;

  always #4 clk = ~clk;

  clkmode_reg uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rmw_op(rmw_op), .addr_hit(addr_hit),
    .wdata(wdata), .reg_o(reg_o), .lock_o(lock_o), .div_sel_o(div_sel_o),
    .eff_div_o(eff_div_o), .ceramic_o(ceramic_o), .main_osc_stop_o(main_osc_stop_o),
    .onchip_osc_stop_o(onchip_osc_stop_o), .onchip_clk_o(onchip_clk_o), .mode_o(mode_o)
  );

  task automatic cmp(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [1:0] model_eff(input logic [7:0] v);
    if (v[7:6] == 2'b01 && !v[5]) return 2'b10;
    return v[7:6];
  endfunction

  task automatic check_all(input string tag);
    cmp({tag, " R1/R2/R3 reg"}, reg_o, m_val);
    cmp({tag, " lock"}, {7'd0, lock_o}, {7'd0, m_lock});
    cmp({tag, " R6 fields"},
        {div_sel_o, ceramic_o, main_osc_stop_o, onchip_osc_stop_o, 1'b0, mode_o},
        {m_val[7:3], 1'b0, m_val[1:0]});
    cmp({tag, " R7 eff_div"}, {6'd0, eff_div_o}, {6'd0, model_eff(m_val)});
    cmp({tag, " R8 onchip"}, {7'd0, onchip_clk_o}, {7'd0, model_eff(m_val) == 2'b00});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_val = 8'h00;
    m_lock = 1'b0;
  endtask

  // R10: sample at the negedge following the access edge.
  task automatic do_access(input logic we, input logic hit, input logic rmw, input logic [7:0] d);
    @(negedge clk);
    wr_en = we; addr_hit = hit; rmw_op = rmw; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr_hit = 1'b0; rmw_op = 1'b0;
    if (we && hit) begin
      if (!rmw && !m_lock) m_val = d;
      else m_val = (m_val & GUARD) | (d & ~GUARD);
      m_lock = 1'b1;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check_all("R1 reset");
  endtask

  task automatic t_first_write();
    do_reset();
    do_access(1, 1, 0, 8'hFF);
    check_all("R2 first write R10");
  endtask

  task automatic t_second_write();
    do_reset();
    do_access(1, 1, 0, 8'h9A);
    do_access(1, 1, 0, 8'h65);
    check_all("R3 second write");
    do_access(1, 1, 0, 8'h00);
    check_all("R3 third write");
  endtask

  task automatic t_rmw_first();
    do_reset();
    do_access(1, 1, 1, 8'hFF);
    check_all("R4 rmw first");
    do_access(1, 1, 0, 8'hFF);
    check_all("R4 plain after rmw");
  endtask

  task automatic t_ignored();
    do_reset();
    do_access(1, 0, 0, 8'hFF);
    check_all("R5 no addr_hit");
    do_access(0, 1, 0, 8'hFF);
    check_all("R5 no wr_en");
    do_access(1, 1, 0, 8'hA5);
    check_all("R5 real access after ignored");
  endtask

  task automatic t_fallback();
    for (int dv = 0; dv < 4; dv++) begin
      for (int s = 0; s < 2; s++) begin
        do_reset();
        do_access(1, 1, 0, {dv[1:0], s[0], 5'b10110});
        check_all($sformatf("R7 div=%0d src=%0d", dv, s));
      end
    end
  endtask

  task automatic t_reopen();
    do_reset();
    do_access(1, 1, 0, 8'h20);
    do_reset();
    check_all("R9 reset after lock");
    do_access(1, 1, 0, 8'h43);
    check_all("R9 reopened write");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_first_write();
    t_second_write();
    t_rmw_first();
    t_ignored();
    t_fallback();
    t_reopen();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule